// File: doc/BRIEF.md
# Vectored Interrupt Controller with Software Requests

This block collects up to 32 interrupt sources and drives two processor request lines: a normal interrupt line and a fast interrupt line. Each source is the OR of a hardware input and a bit that software can set. An enable mask gates the sources. A routing mask then sends each enabled source to one of the two lines. Enables are turned on through one register and turned off through another, and each of the two ignores zero bits. Software requests work the same way, with a set register and a clear register.

For the normal line, each source has a programmable handler address. A read of the vector-address register returns the handler address of the lowest-numbered pending source and places that source in service. While a source is in service, this instance's own sources no longer drive the normal line. A write to the vector-address register ends service. If a source is still pending at that point, the line rises again. Several instances chain together: a downstream instance feeds its request and its candidate vector into `chain_irq_i` and `chain_vec_i` of the next instance up. A vector read returns the chained vector when nothing local is pending or in service.

All registers sit on a simple register bus with write and read strobes. Read data is registered and appears one cycle after the read strobe.

Top module: `ivc_top`

## Requirements
- R1: The raw request word (read at byte offset 0x08) is the bitwise OR of `src_i` and the software request word. Bit i stands for source i.
- R2: A write to offset 0x10 sets every enable bit that is 1 in the written data and leaves all other enable bits unchanged. A read at 0x10 returns the enable mask, which is zero after reset.
- R3: A write to offset 0x14 clears every enable bit that is 1 in the written data and leaves all other enable bits unchanged.
- R4: The routing mask at offset 0x0C is written and read directly. Bit 1 sends a source to the fast line and bit 0 sends it to the normal line. The mask is zero after reset.
- R5: The normal status word (0x00) equals raw AND enable AND NOT routing. The fast status word (0x04) equals raw AND enable AND routing. `fiq_o` is high exactly when the fast status word is nonzero.
- R6: `irq_o` is high when the normal status word is nonzero and no source is in service, or when `chain_irq_i` is high.
- R7: A write to 0x18 sets software request bits that are 1 in the data, and a write to 0x1C clears them. A read at 0x18 returns the software request word. A set software bit raises the source like its hardware line.
- R8: The handler address of source i is written and read at offset 0x100 + 4*i. All handler addresses are zero after reset.
- R9: A read at 0xF00 with no source in service returns the handler address of the lowest-numbered set bit of the normal status word. If such a bit exists, that source enters service.
- R10: While a source is in service, further reads at 0xF00 return the same handler address, and the local sources do not drive `irq_o`.
- R11: A write at 0xF00 ends service. If the normal status word is still nonzero, `irq_o` is high in the next cycle.
- R12: When no source is in service and the normal status word is zero, a read at 0xF00 returns `chain_vec_i`. `vec_o` carries the winning local handler address when the normal status word is nonzero and `chain_vec_i` otherwise.
- R13: `bus_rdata_o` is zero in any cycle that follows a cycle without a read strobe. Reads at unaligned or unmapped offsets return zero. Writes to those offsets, and writes to the status and raw words, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Hardware interrupt lines, one per source |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 12 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| chain_irq_i | input | 1 | Normal request from a downstream instance |
| chain_vec_i | input | VEC_W | Candidate vector from a downstream instance |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| vec_o | output | VEC_W | Candidate vector for an upstream instance |

## Verification
The assertions take for granted that the read and write strobes are never high in the same cycle. They also assume that reset is high on the first clock edge, and that `src_i` and the chain inputs change only away from the active clock edge. The stimulus drives every input on the falling edge. It issues exactly one operation per cycle, either a write, a read or an idle cycle, so no cycle carries both strobes. Reset is held for several cycles before the first operation.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int SRC_COUNT = 32;
    localparam int BUS_W     = 32;
    localparam int VEC_W     = 32;
    localparam int ADDR_W    = 12;
    localparam int VIDX_W    = 8;

    localparam logic [ADDR_W-1:0] OFF_IRQ_STAT = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_FIQ_STAT = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_RAW      = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_ROUTE    = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_EN_SET   = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_EN_CLR   = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_SW_SET   = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_SW_CLR   = 12'h01C;
    localparam logic [ADDR_W-1:0] OFF_VEC_BASE = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_VADDR    = 12'hF00;

    typedef enum logic [3:0] {
        RS_NONE,
        RS_IRQ_STAT,
        RS_FIQ_STAT,
        RS_RAW,
        RS_ROUTE,
        RS_EN_SET,
        RS_EN_CLR,
        RS_SW_SET,
        RS_SW_CLR,
        RS_VEC,
        RS_VADDR
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e                sel;
        logic                    wr;
        logic                    rd;
        logic [VIDX_W-1:0]       vidx;
    } bus_op_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a, input int nsrc);
        reg_sel_e r;
        r = RS_NONE;
        if (a[1:0] == 2'b00) begin
            case (a)
                OFF_IRQ_STAT: r = RS_IRQ_STAT;
                OFF_FIQ_STAT: r = RS_FIQ_STAT;
                OFF_RAW:      r = RS_RAW;
                OFF_ROUTE:    r = RS_ROUTE;
                OFF_EN_SET:   r = RS_EN_SET;
                OFF_EN_CLR:   r = RS_EN_CLR;
                OFF_SW_SET:   r = RS_SW_SET;
                OFF_SW_CLR:   r = RS_SW_CLR;
                OFF_VADDR:    r = RS_VADDR;
                default: begin
                    if (int'(a) >= int'(OFF_VEC_BASE) &&
                        int'(a) < int'(OFF_VEC_BASE) + 4 * nsrc)
                        r = RS_VEC;
                end
            endcase
        end
        return r;
    endfunction

    function automatic logic [VIDX_W-1:0] vec_index(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-3:0] w;
        w = a[ADDR_W-1:2] - OFF_VEC_BASE[ADDR_W-1:2];
        return w[VIDX_W-1:0];
    endfunction

endpackage

// File: rtl/ivc_cfg_regs.sv
module ivc_cfg_regs
    import ivc_pkg::*;
#(
    parameter int NUM_SRC = SRC_COUNT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  reg_sel_e           sel,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] route_q,
    output logic [NUM_SRC-1:0] soft_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            route_q <= '0;
            soft_q  <= '0;
        end else if (wr) begin
            case (sel)
                RS_EN_SET: en_q    <= en_q | wdata;
                RS_EN_CLR: en_q    <= en_q & ~wdata;
                RS_ROUTE:  route_q <= wdata;
                RS_SW_SET: soft_q  <= soft_q | wdata;
                RS_SW_CLR: soft_q  <= soft_q & ~wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ivc_prio_pick.sv
module ivc_prio_pick #(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/ivc_vector_bank.sv
module ivc_vector_bank #(
    parameter int NUM_SRC = 32,
    parameter int VEC_W   = 32,
    parameter int IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [IDX_W-1:0] widx,
    input  logic [VEC_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx_a,
    output logic [VEC_W-1:0] rdata_a,
    input  logic [IDX_W-1:0] ridx_b,
    output logic [VEC_W-1:0] rdata_b
);

    logic [VEC_W-1:0] slot [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        logic [VEC_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr && widx == IDX_W'(g))
                q <= wdata;
        end
        assign slot[g] = q;
    end

    assign rdata_a = slot[ridx_a];
    assign rdata_b = slot[ridx_b];

endmodule

// File: rtl/ivc_top.sv
module ivc_top
    import ivc_pkg::*;
#(
    parameter int NUM_SRC = SRC_COUNT,
    parameter int VEC_W   = ivc_pkg::VEC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [BUS_W-1:0]   bus_wdata_i,
    output logic [BUS_W-1:0]   bus_rdata_o,
    input  logic               chain_irq_i,
    input  logic [VEC_W-1:0]   chain_vec_i,
    output logic               irq_o,
    output logic               fiq_o,
    output logic [VEC_W-1:0]   vec_o
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    bus_op_t            op;
    logic [VIDX_W-1:0]  vidx_full;
    logic [IDX_W-1:0]   vidx;
    logic [NUM_SRC-1:0] en_q, route_q, soft_q;
    logic [NUM_SRC-1:0] raw, irq_stat, fiq_stat;
    logic               any_irq;
    logic [IDX_W-1:0]   win_idx;
    logic [VEC_W-1:0]   bus_vec, win_vec, vaddr_val;
    logic               svc_q;
    logic [VEC_W-1:0]   svc_vec_q;
    logic [BUS_W-1:0]   rd_mux;

    assign vidx_full = vec_index(bus_addr_i);
    assign vidx      = vidx_full[IDX_W-1:0];
    assign op.sel    = decode_sel(bus_addr_i, NUM_SRC);
    assign op.wr     = bus_wr_i;
    assign op.rd     = bus_rd_i;
    assign op.vidx   = vidx_full;

    ivc_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr      (op.wr),
        .sel     (op.sel),
        .wdata   (bus_wdata_i[NUM_SRC-1:0]),
        .en_q    (en_q),
        .route_q (route_q),
        .soft_q  (soft_q)
    );

    assign raw      = src_i | soft_q;
    assign irq_stat = raw & en_q & ~route_q;
    assign fiq_stat = raw & en_q & route_q;

    ivc_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .req (irq_stat),
        .any (any_irq),
        .idx (win_idx)
    );

    ivc_vector_bank #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_vecs (
        .clk     (clk),
        .rst     (rst),
        .wr      (op.wr && op.sel == RS_VEC),
        .widx    (vidx),
        .wdata   (bus_wdata_i[VEC_W-1:0]),
        .ridx_a  (vidx),
        .rdata_a (bus_vec),
        .ridx_b  (win_idx),
        .rdata_b (win_vec)
    );

    assign fiq_o     = |fiq_stat;
    assign irq_o     = (any_irq && !svc_q) || chain_irq_i;
    assign vec_o     = any_irq ? win_vec : chain_vec_i;
    assign vaddr_val = svc_q ? svc_vec_q : vec_o;

    always_comb begin
        rd_mux = '0;
        case (op.sel)
            RS_IRQ_STAT: rd_mux = BUS_W'(irq_stat);
            RS_FIQ_STAT: rd_mux = BUS_W'(fiq_stat);
            RS_RAW:      rd_mux = BUS_W'(raw);
            RS_ROUTE:    rd_mux = BUS_W'(route_q);
            RS_EN_SET:   rd_mux = BUS_W'(en_q);
            RS_SW_SET:   rd_mux = BUS_W'(soft_q);
            RS_VEC:      rd_mux = BUS_W'(bus_vec);
            RS_VADDR:    rd_mux = BUS_W'(vaddr_val);
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata_o <= '0;
            svc_q       <= 1'b0;
            svc_vec_q   <= '0;
        end else begin
            bus_rdata_o <= op.rd ? rd_mux : '0;
            if (op.wr && op.sel == RS_VADDR) begin
                svc_q <= 1'b0;
            end else if (op.rd && op.sel == RS_VADDR && !svc_q && any_irq) begin
                svc_q     <= 1'b1;
                svc_vec_q <= win_vec;
            end
        end
    end

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
    import ivc_pkg::*;
#(
    parameter int NUM_SRC = SRC_COUNT,
    parameter int VEC_W   = ivc_pkg::VEC_W
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr_i,
    input logic               bus_rd_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [BUS_W-1:0]   bus_wdata_i,
    input logic [BUS_W-1:0]   bus_rdata_o,
    input logic               chain_irq_i,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] route_q,
    input logic [NUM_SRC-1:0] soft_q,
    input logic               svc_q
);

    reg_sel_e chk_sel;
    assign chk_sel = decode_sel(bus_addr_i, NUM_SRC);

    AST_EN_SET_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && chk_sel == RS_EN_SET) |=>
            ((en_q & $past(bus_wdata_i[NUM_SRC-1:0])) == $past(bus_wdata_i[NUM_SRC-1:0])) &&
            ((en_q & $past(en_q)) == $past(en_q))); // R2

    AST_EN_CLR_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && chk_sel == RS_EN_CLR) |=>
            ((en_q & $past(bus_wdata_i[NUM_SRC-1:0])) == '0) &&
            ((en_q | $past(bus_wdata_i[NUM_SRC-1:0])) ==
             ($past(en_q) | $past(bus_wdata_i[NUM_SRC-1:0])))); // R3

    AST_ROUTE_RESET_IRQ: assert property (@(posedge clk)
        rst |=> (route_q == '0)); // R4

    AST_SOFT_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (((soft_q & en_q & ~route_q) != '0) && !svc_q) |-> irq_o); // R7

    AST_NO_IRQ_IN_SERVICE: assert property (@(posedge clk) disable iff (rst)
        (svc_q && !chain_irq_i) |-> !irq_o); // R10

    AST_ACK_ENDS_SERVICE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && chk_sel == RS_VADDR) |=> !svc_q); // R11

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_i |=> (bus_rdata_o == '0)); // R13

endmodule

bind ivc_top ivc_checker #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .chain_irq_i (chain_irq_i),
    .irq_o       (irq_o),
    .en_q        (en_q),
    .route_q     (route_q),
    .soft_q      (soft_q),
    .svc_q       (svc_q)
);

// File: tb/ivc_top_tb.sv
`timescale 1ns/1ps
module ivc_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        chain_irq = 1'b0;
    logic [31:0] chain_vec = '0;
    logic        irq, fiq;
    logic [31:0] vec_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ivc_top u_dut (
        .clk(clk), .rst(rst), .src_i(src),
        .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .chain_irq_i(chain_irq), .chain_vec_i(chain_vec),
        .irq_o(irq), .fiq_o(fiq), .vec_o(vec_out)
    );

    // behavioural reference state
    logic [31:0] m_en, m_route, m_soft, m_svc_vec, m_rd;
    logic [31:0] m_vec [32];
    bit          m_svc;

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_for(input logic [11:0] a);
        if (a == 12'h000 || a == 12'h004) return "R5";
        if (a == 12'h008) return "R1";
        if (a == 12'h00C) return "R4";
        if (a == 12'h010) return "R2";
        if (a == 12'h014) return "R3";
        if (a == 12'h018 || a == 12'h01C) return "R7";
        if (a >= 12'h100 && a < 12'h180) return "R8";
        if (a == 12'hF00) return "R9";
        return "R13";
    endfunction

    function automatic bit is_vec(input logic [11:0] a);
        return a >= 12'h100 && a < 12'h180 && a[1:0] == 2'b00;
    endfunction

    logic [11:0] last_rd_addr;

    always @(posedge clk) begin
        logic [31:0] raw, ist, fst, cand;
        int win;
        if (rst) begin
            m_en = '0; m_route = '0; m_soft = '0; m_svc = 0; m_svc_vec = '0; m_rd = '0;
            for (int i = 0; i < 32; i++) m_vec[i] = '0;
        end else begin
            raw = src | m_soft;
            ist = raw & m_en & ~m_route;
            win = -1;
            for (int i = 31; i >= 0; i--) if (ist[i]) win = i;
            cand = (win >= 0) ? m_vec[win] : chain_vec;
            m_rd = '0;
            last_rd_addr = bus_addr;
            if (bus_rd) begin
                fst = raw & m_en & m_route;
                case (bus_addr)
                    12'h000: m_rd = ist;
                    12'h004: m_rd = fst;
                    12'h008: m_rd = raw;
                    12'h00C: m_rd = m_route;
                    12'h010: m_rd = m_en;
                    12'h018: m_rd = m_soft;
                    12'hF00: begin
                        m_rd = m_svc ? m_svc_vec : cand;
                        if (!m_svc && win >= 0) begin
                            m_svc = 1;
                            m_svc_vec = m_vec[win];
                        end
                    end
                    default: if (is_vec(bus_addr)) m_rd = m_vec[(bus_addr - 12'h100) >> 2];
                endcase
            end
            if (bus_wr) begin
                case (bus_addr)
                    12'h00C: m_route = bus_wdata;
                    12'h010: m_en = m_en | bus_wdata;
                    12'h014: m_en = m_en & ~bus_wdata;
                    12'h018: m_soft = m_soft | bus_wdata;
                    12'h01C: m_soft = m_soft & ~bus_wdata;
                    12'hF00: m_svc = 0;
                    default: if (is_vec(bus_addr)) m_vec[(bus_addr - 12'h100) >> 2] = bus_wdata;
                endcase
            end
        end
        #1;
        if (!rst && !finished) begin
            raw = src | m_soft;
            ist = raw & m_en & ~m_route;
            fst = raw & m_en & m_route;
            win = -1;
            for (int i = 31; i >= 0; i--) if (ist[i]) win = i;
            check_eq("R6 irq_o", {31'b0, irq}, {31'b0, ((ist != 0) && !m_svc) || chain_irq});
            check_eq("R5 fiq_o", {31'b0, fiq}, {31'b0, fst != 0});
            check_eq("R12 vec_o", vec_out, (win >= 0) ? m_vec[win] : chain_vec);
            check_eq(tag_for(last_rd_addr), bus_rdata, m_rd);
        end
    end

    task automatic cyc(input logic we, input logic re, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = we; bus_rd = re; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b0, a, d);
    endtask

    task automatic nop();
        cyc(1'b0, 1'b0, 12'h000, 32'h0);
    endtask

    task automatic settle();
        @(posedge clk);
        #1.2;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        cyc(1'b0, 1'b1, a, 32'h0);
        settle();
        check_eq(tag, bus_rdata, exp);
    endtask

    function automatic logic [31:0] vval(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h10;
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // reset state
        rd_chk(12'h010, 32'h0, "R2 enable reset");
        rd_chk(12'h00C, 32'h0, "R4 route reset");
        rd_chk(12'h104, 32'h0, "R8 vector reset");
        rd_chk(12'hF00, 32'h0, "R12 empty vector read");
        // handler addresses
        for (int i = 0; i < 32; i++) wr(12'h100 + 12'(4 * i), vval(i));
        rd_chk(12'h114, vval(5), "R8 vector readback");
        // raw without enable
        cyc(1'b0, 1'b0, 12'h0, 32'h0); src = 32'h0000_0008;
        rd_chk(12'h008, 32'h0000_0008, "R1 raw shows source");
        rd_chk(12'h000, 32'h0, "R5 masked status");
        check_eq("R6 irq low while masked", {31'b0, irq}, 32'h0);
        // enable set
        wr(12'h010, 32'h0000_0088);
        wr(12'h010, 32'h0);
        settle();
        rd_chk(12'h010, 32'h0000_0088, "R2 zero write keeps enables");
        check_eq("R6 irq high", {31'b0, irq}, 32'h1);
        // vector read and service
        rd_chk(12'hF00, vval(3), "R9 winning vector");
        check_eq("R10 irq masked in service", {31'b0, irq}, 32'h0);
        nop(); src = 32'h0000_000A;
        wr(12'h010, 32'h0000_0002);
        rd_chk(12'hF00, vval(3), "R10 same vector in service");
        wr(12'hF00, 32'h0);
        settle();
        check_eq("R11 irq refires after ack", {31'b0, irq}, 32'h1);
        rd_chk(12'hF00, vval(1), "R9 lowest index wins");
        wr(12'hF00, 32'h0);
        // routing
        wr(12'h00C, 32'h0000_0002);
        settle();
        check_eq("R4 routed to fast line", {31'b0, fiq}, 32'h1);
        rd_chk(12'h004, 32'h0000_0002, "R5 fast status");
        rd_chk(12'h000, 32'h0000_0008, "R5 normal status");
        // enable clear
        wr(12'h014, 32'h0000_0008);
        rd_chk(12'h010, 32'h0000_0082, "R3 clear one enable");
        wr(12'h014, 32'h0);
        rd_chk(12'h010, 32'h0000_0082, "R3 zero clear keeps enables");
        // software requests
        nop(); src = 32'h0;
        wr(12'h010, 32'h0010_0000);
        wr(12'h018, 32'h0010_0000);
        settle();
        check_eq("R7 soft raises irq", {31'b0, irq}, 32'h1);
        rd_chk(12'h018, 32'h0010_0000, "R7 soft readback");
        rd_chk(12'hF00, vval(20), "R9 soft source vector");
        wr(12'hF00, 32'h0);
        settle();
        check_eq("R11 soft refires", {31'b0, irq}, 32'h1);
        wr(12'h01C, 32'h0010_0000);
        settle();
        check_eq("R7 soft cleared", {31'b0, irq}, 32'h0);
        // chaining
        nop(); chain_irq = 1'b1; chain_vec = 32'hCAFE_0000;
        settle();
        check_eq("R6 chain request", {31'b0, irq}, 32'h1);
        check_eq("R12 chain vec_o", vec_out, 32'hCAFE_0000);
        rd_chk(12'hF00, 32'hCAFE_0000, "R12 chain vector read");
        nop(); chain_irq = 1'b0;
        // unmapped and unaligned
        rd_chk(12'h012, 32'h0, "R13 unaligned read");
        rd_chk(12'h200, 32'h0, "R13 unmapped read");
        wr(12'h012, 32'hFFFF_FFFF);
        wr(12'h008, 32'hFFFF_FFFF);
        rd_chk(12'h010, 32'h0010_0082, "R13 stray writes ignored");
        // mixed traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int k;
            logic [11:0] a;
            logic [31:0] d;
            k = int'($urandom_range(0, 11));
            case (k)
                0: a = 12'h000;  1: a = 12'h004;  2: a = 12'h008;  3: a = 12'h00C;
                4: a = 12'h010;  5: a = 12'h014;  6: a = 12'h018;  7: a = 12'h01C;
                8, 9: a = 12'hF00;
                default: a = 12'h100 + 12'(4 * $urandom_range(0, 31));
            endcase
            d = $urandom() & $urandom() & $urandom();
            case ($urandom_range(0, 2))
                0: cyc(1'b1, 1'b0, a, d);
                1: cyc(1'b0, 1'b1, a, 32'h0);
                default: cyc(1'b0, 1'b0, a, d);
            endcase
            if ($urandom_range(0, 7) == 0) src = $urandom() & $urandom();
            if ($urandom_range(0, 15) == 0) begin
                chain_irq = 1'($urandom_range(0, 1));
                chain_vec = $urandom();
            end
        end
        nop();
        settle();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule